// File: doc/BRIEF.md
# Protected Media-Interface Converter Register Block

This block holds the control state of a five-port Ethernet media-interface converter. Software reaches it over a simple 32-bit register bus with an address, write data, a write strobe, a read strobe and registered read data. The block keeps the global switch configuration mode, one control word per converter port (interface kind, line rate, duplex), the per-port converter run/reset mask and two switch override masks. It drives all of this state, decoded per port, to its output pins, where the converter datapath picks it up.

All registers apart from the command register are protected. Software first writes a fixed four-word key to the command register. Only after that do writes to the protected registers take effect. A protected write made while locked, or a wrong key word, is dropped. It sends the key sequence back to its start and raises a one-cycle error pulse. The in-band link status of each port comes in on input pins and can be read in the upper half of that port's control word.

Top module: `miiconv_regs`

## Requirements
- R1: After reset every port is held in converter reset (`port_run_o` = 0), every other output is zero, and every register reads as zero.
- R2: Protected writes take effect only after four writes to offset 0x000 carrying 0x00A5, 0x0001, 0xFFFE and 0x0001, in that order; after only three of them a protected write is still refused.
- R3: A write to a protected offset (0x020, 0x100..0x110, 0x114, 0x304, 0x308) while locked is dropped, sends the key sequence back to its start, and makes `prot_err_o` high for exactly the one cycle after that write.
- R4: A write to offset 0x000 whose value does not match the expected key word is dropped, restarts the key sequence and raises the same one-cycle `prot_err_o` pulse.
- R5: Once unlocked, the block accepts any number of protected writes. Any later write to offset 0x000 starts a new key attempt, so that locks the block again; a non-key value there also raises `prot_err_o`.
- R6: Offset 0x020 holds the switch configuration mode in bits 4:0. These bits drive `sw_mode_o` and read back; the other bits read zero.
- R7: The control word of port p (p = 0..4) is at offset 0x100 + 4*p. Bits 1:0 hold the rate (0 = 10, 1 = 100, 2 = 1000 Mb/s), bits 3:2 the interface (0 = MII, 1 = RMII, 2 = RGMII) and bit 8 full duplex. These drive `port_speed_o[2p+1:2p]`, `port_iface_o[2p+1:2p]` and `port_fdx_o[p]`.
- R8: When a port's interface field is MII (0), its rate field reads as 0 and drives 0, whatever rate was written.
- R9: Bits 12 (link), 13 (duplex) and 15:14 (rate) of port p's control word read the nibble `link_stat_i[4p+3:4p]`, ordered {rate[1:0], duplex, link} and registered once. Writes to these bits have no effect.
- R10: Offset 0x114 bit p releases port p from converter reset (1 = running) and drives `port_run_o[p]`; bits above 4 read zero.
- R11: Offsets 0x304 and 0x308 hold five-bit switch rate and duplex override masks (zero leaves control to the switch). They drive `sw_spd_o` and `sw_dup_o` and read back.
- R12: Read data appears on `rdata_o` in the cycle after `rd_i` and is zero otherwise. Offset 0x000 and unmapped offsets read as zero, and writes to unmapped offsets are dropped without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| link_stat_i | input | 20 | Per-port in-band status nibbles {rate, duplex, link} |
| prot_err_o | output | 1 | One-cycle pulse for a refused write |
| sw_mode_o | output | 5 | Switch configuration mode |
| port_iface_o | output | 10 | Per-port interface kind, 2 bits each |
| port_speed_o | output | 10 | Per-port line rate, 2 bits each |
| port_fdx_o | output | 5 | Per-port full duplex |
| port_run_o | output | 5 | Per-port converter run (1) / reset (0) |
| sw_spd_o | output | 5 | Switch rate override mask |
| sw_dup_o | output | 5 | Switch duplex override mask |

## Verification
The properties assume that a write and a read are never strobed in the same cycle. They also assume that the bus holds address and data steady only for the cycle of its strobe, and that `link_stat_i` changes only between clock edges. The bench keeps to this by driving every strobe for a single cycle from the falling edge and never overlapping reads with writes. It sets the status pins only while the bus is idle and waits two cycles before reading them back.

// File: rtl/miiconv_regs.sv
module miiconv_regs #(
  parameter int NPORT  = 5,
  parameter int AW     = 12,
  parameter int DW     = 32,
  parameter int MODE_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [4*NPORT-1:0]   link_stat_i,
  output logic                 prot_err_o,
  output logic [MODE_W-1:0]    sw_mode_o,
  output logic [2*NPORT-1:0]   port_iface_o,
  output logic [2*NPORT-1:0]   port_speed_o,
  output logic [NPORT-1:0]     port_fdx_o,
  output logic [NPORT-1:0]     port_run_o,
  output logic [NPORT-1:0]     sw_spd_o,
  output logic [NPORT-1:0]     sw_dup_o
);

  localparam logic [AW-1:0] A_CMD   = AW'(12'h000);
  localparam logic [AW-1:0] A_MODE  = AW'(12'h020);
  localparam logic [AW-1:0] A_PORT0 = AW'(12'h100);
  localparam logic [AW-1:0] A_RUN   = AW'(12'h114);
  localparam logic [AW-1:0] A_SSPD  = AW'(12'h304);
  localparam logic [AW-1:0] A_SDUP  = AW'(12'h308);
  localparam logic [2:0]    OPEN    = 3'd4;

  function automatic logic [DW-1:0] key_at(input logic [2:0] idx);
    case (idx)
      3'd0:    key_at = DW'(16'h00A5);
      3'd2:    key_at = DW'(16'hFFFE);
      default: key_at = DW'(16'h0001);
    endcase
  endfunction

  logic [2:0]       kidx;
  logic [NPORT-1:0] port_hit;
  logic [DW-1:0]    port_word [NPORT];

  wire unlocked  = (kidx == OPEN);
  wire [2:0] kbase = unlocked ? 3'd0 : kidx;
  wire key_ok    = (wdata_i == key_at(kbase));
  wire prot_hit  = (addr_i == A_MODE) || (|port_hit) || (addr_i == A_RUN) ||
                   (addr_i == A_SSPD) || (addr_i == A_SDUP);
  wire cmd_wr    = wr_i && (addr_i == A_CMD);
  wire prot_wr   = wr_i && prot_hit;
  wire wr_ok     = prot_wr && unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kidx       <= 3'd0;
      prot_err_o <= 1'b0;
    end else begin
      prot_err_o <= (cmd_wr && !key_ok) || (prot_wr && !unlocked);
      if (cmd_wr)
        kidx <= key_ok ? 3'(kbase + 3'd1) : 3'd0;
      else if (prot_wr && !unlocked)
        kidx <= 3'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_mode_o  <= '0;
      port_run_o <= '0;
      sw_spd_o   <= '0;
      sw_dup_o   <= '0;
    end else if (wr_ok) begin
      if (addr_i == A_MODE) sw_mode_o  <= wdata_i[MODE_W-1:0];
      if (addr_i == A_RUN)  port_run_o <= wdata_i[NPORT-1:0];
      if (addr_i == A_SSPD) sw_spd_o   <= wdata_i[NPORT-1:0];
      if (addr_i == A_SDUP) sw_dup_o   <= wdata_i[NPORT-1:0];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [1:0] spd_q, ifc_q;
    logic       fdx_q;
    logic [3:0] stat_q;

    assign port_hit[p] = (addr_i == AW'(A_PORT0 + AW'(4 * p)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        spd_q  <= '0;
        ifc_q  <= '0;
        fdx_q  <= 1'b0;
        stat_q <= '0;
      end else begin
        stat_q <= link_stat_i[4*p +: 4];
        if (wr_ok && port_hit[p]) begin
          ifc_q <= wdata_i[3:2];
          spd_q <= (wdata_i[3:2] == 2'd0) ? 2'd0 : wdata_i[1:0];
          fdx_q <= wdata_i[8];
        end
      end
    end

    assign port_word[p] = DW'({stat_q, 3'b000, fdx_q, 4'b0000, ifc_q, spd_q});
    assign port_iface_o[2*p +: 2] = ifc_q;
    assign port_speed_o[2*p +: 2] = spd_q;
    assign port_fdx_o[p]          = fdx_q;
  end

  logic [DW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (addr_i == A_MODE) rd_val = DW'(sw_mode_o);
    if (addr_i == A_RUN)  rd_val = DW'(port_run_o);
    if (addr_i == A_SSPD) rd_val = DW'(sw_spd_o);
    if (addr_i == A_SDUP) rd_val = DW'(sw_dup_o);
    for (int i = 0; i < NPORT; i++)
      if (port_hit[i]) rd_val = port_word[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
    else           rdata_o <= '0;
  end

endmodule

// File: rtl/miiconv_regs_chk.sv
module miiconv_regs_chk #(
  parameter int NPORT  = 5,
  parameter int DW     = 32,
  parameter int MODE_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_i,
  input logic               rd_i,
  input logic [DW-1:0]      rdata_o,
  input logic               prot_err_o,
  input logic [MODE_W-1:0]  sw_mode_o,
  input logic [2*NPORT-1:0] port_iface_o,
  input logic [2*NPORT-1:0] port_speed_o,
  input logic [NPORT-1:0]   port_run_o,
  input logic [NPORT-1:0]   port_fdx_o
);

  // R3
  err_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err_o |-> $past(wr_i));

  // R3
  refused_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err_o |-> ($stable(sw_mode_o) && $stable(port_run_o) &&
                    $stable(port_iface_o) && $stable(port_fdx_o)));

  // R6
  state_holds_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(sw_mode_o) && $stable(port_run_o) && $stable(port_iface_o)));

  // R12
  rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> (rdata_o == '0));

  for (genvar p = 0; p < NPORT; p++) begin : g_mii
    // R8
    mii_rate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_iface_o[2*p +: 2] == 2'd0) |-> (port_speed_o[2*p +: 2] == 2'd0));
  end

endmodule

bind miiconv_regs miiconv_regs_chk #(.NPORT(NPORT), .DW(DW), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o),
  .prot_err_o(prot_err_o), .sw_mode_o(sw_mode_o), .port_iface_o(port_iface_o),
  .port_speed_o(port_speed_o), .port_run_o(port_run_o), .port_fdx_o(port_fdx_o)
);

// File: tb/miiconv_regs_bench.sv
module miiconv_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [19:0] link_stat_i = '0;
  logic [31:0] rdata_o;
  logic        prot_err_o;
  logic [4:0]  sw_mode_o, port_fdx_o, port_run_o, sw_spd_o, sw_dup_o;
  logic [9:0]  port_iface_o, port_speed_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic last_err;
  logic rd_pend = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  miiconv_regs u_miiconv_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i), .wr_i(wr_i),
    .rd_i(rd_i), .rdata_o(rdata_o), .link_stat_i(link_stat_i),
    .prot_err_o(prot_err_o), .sw_mode_o(sw_mode_o), .port_iface_o(port_iface_o),
    .port_speed_o(port_speed_o), .port_fdx_o(port_fdx_o), .port_run_o(port_run_o),
    .sw_spd_o(sw_spd_o), .sw_dup_o(sw_dup_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
    last_err = prot_err_o;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr_i = a; rd_i = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  always @(posedge clk) rd_pend <= rd_i;

  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      automatic logic [31:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(t, rdata_o, e);
    end
  end

  task automatic unlock();
    wr(12'h000, 32'h00A5); check("R2 key0 accepted", 32'(last_err), 0);
    wr(12'h000, 32'h0001); check("R2 key1 accepted", 32'(last_err), 0);
    wr(12'h000, 32'hFFFE); check("R2 key2 accepted", 32'(last_err), 0);
    wr(12'h000, 32'h0001); check("R2 key3 accepted", 32'(last_err), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 run mask", 32'(port_run_o), 0);
    check("R1 mode", 32'(sw_mode_o), 0);
    check("R1 iface", 32'(port_iface_o), 0);
    check("R1 err", 32'(prot_err_o), 0);
    rst_n = 1'b1;
    rd(12'h020, 0, "R1 mode reads zero");
    rd(12'h114, 0, "R1 run reads zero");
    rd(12'h104, 0, "R1 port1 reads zero");

    wr(12'h020, 32'h0000_0007);
    check("R3 locked write error", 32'(last_err), 1);
    @(negedge clk);
    check("R3 pulse one cycle", 32'(prot_err_o), 0);
    check("R3 mode unchanged", 32'(sw_mode_o), 0);
    rd(12'h020, 0, "R3 mode readback");

    wr(12'h000, 32'h00A5);
    wr(12'h000, 32'h0002);
    check("R4 bad key error", 32'(last_err), 1);
    wr(12'h000, 32'h0001);
    check("R4 sequence restarted", 32'(last_err), 1);

    wr(12'h000, 32'h00A5); wr(12'h000, 32'h0001); wr(12'h000, 32'hFFFE);
    wr(12'h114, 32'h1F);
    check("R2 three keys not enough", 32'(last_err), 1);
    check("R2 run unchanged", 32'(port_run_o), 0);

    unlock();
    wr(12'h020, 32'h0000_00F3);
    check("R2 write accepted", 32'(last_err), 0);
    check("R6 mode out", 32'(sw_mode_o), 32'h13);
    rd(12'h020, 32'h13, "R6 mode readback");

    for (int p = 0; p < 5; p++) begin
      automatic logic [31:0] w = ((p & 1) << 8) | (2 << 2) | (p % 3);
      wr(12'h100 + 12'(4 * p), w | 32'hFFFF_0000);
      check("R5 still unlocked", 32'(last_err), 0);
      check("R7 iface out", 32'(port_iface_o[2*p +: 2]), 2);
      check("R7 rate out", 32'(port_speed_o[2*p +: 2]), 32'(p % 3));
      check("R7 fdx out", 32'(port_fdx_o[p]), 32'(p & 1));
      rd(12'h100 + 12'(4 * p), w, "R7 control readback");
    end

    wr(12'h108, 32'h0000_0103);
    check("R8 rate out zero", 32'(port_speed_o[5:4]), 0);
    check("R8 iface out", 32'(port_iface_o[5:4]), 0);
    rd(12'h108, 32'h0000_0100, "R8 rate reads zero");

    @(negedge clk);
    link_stat_i[7:4] = 4'b1011;
    repeat (2) @(negedge clk);
    rd(12'h104, 32'h0000_B109, "R9 status bits");
    wr(12'h100, 32'h0000_F008);
    rd(12'h100, 32'h0000_0008, "R9 status write ignored");

    wr(12'h114, 32'h0000_0015);
    check("R10 run out", 32'(port_run_o), 32'h15);
    rd(12'h114, 32'h15, "R10 run readback");
    wr(12'h114, 32'hFFFF_FFEA);
    rd(12'h114, 32'h0A, "R10 upper bits dropped");

    wr(12'h304, 32'h0000_001F);
    wr(12'h308, 32'h0000_0009);
    check("R11 rate mask out", 32'(sw_spd_o), 32'h1F);
    check("R11 duplex mask out", 32'(sw_dup_o), 32'h09);
    rd(12'h304, 32'h1F, "R11 rate readback");
    rd(12'h308, 32'h09, "R11 duplex readback");

    rd(12'h200, 0, "R12 unmapped reads zero");
    rd(12'h000, 0, "R12 command reads zero");
    wr(12'h200, 32'hDEAD_BEEF);
    check("R12 unmapped write no error", 32'(last_err), 0);
    @(negedge clk);
    check("R12 rdata idle zero", rdata_o, 0);

    wr(12'h000, 32'h0000_0001);
    check("R5 new attempt bad key", 32'(last_err), 1);
    wr(12'h020, 32'h0000_0001);
    check("R5 relocked refuses", 32'(last_err), 1);
    rd(12'h020, 32'h13, "R5 mode kept");

    repeat (3) @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule